// File: doc/BRIEF.md
# Converter Start-Up and Output Mute Sequencer

This block decides when converted audio samples may reach the serial output of a converter. After the supply-good flag goes high it keeps the digital core in reset for a fixed number of system-clock cycles. It then mutes the output, forcing zero data, while it counts a fixed number of sample periods so that the filters can settle. Only after both phases does it let real data through. The mute is lifted on the clock edge that samples a sample tick, so the first unmuted frame is always a whole frame.

An active-low power-down input overrides every phase. While it is low the block drops the digital clock enable and the data output enable, and holds reset and mute. When power-down is released the whole sequence starts again from the system-clock phase. Power-down is the intended way to re-initialise the converter after a change of rate, mode, format or oversampling setting.

A low supply-good flag resets the sequencer at once, without waiting for a clock edge, and clears its counter.

Top module: `adc_startup_seq`

## Requirements
- R1: While `supply_ok` is low the outputs are `core_rst`=1, `force_zero`=1, `dout_en`=1 and `clk_en`=1. This takes effect at once, with no clock edge, and clears the sequence.
- R2: After `supply_ok` rises, `core_rst` stays high for exactly RST_CYCLES rising clock edges, then falls.
- R3: Only `fs_tick` pulses sampled after `core_rst` has fallen count toward the settle interval. A tick sampled on the edge that releases reset is not counted.
- R4: `force_zero` falls on the clock edge that samples the SETTLE_SAMPLES-th counted tick, with `fs_tick` high at that edge. It does not fall earlier.
- R5: When `pdn_n` is low at a rising edge, then after that edge `clk_en`=0, `dout_en`=0, `core_rst`=1 and `force_zero`=1, whatever phase the block was in.
- R6: When `pdn_n` returns high, the first edge enters reset. `core_rst` then stays high for RST_CYCLES+1 edges in total, and the settle interval repeats in full.
- R7: If `pdn_n` is low on the same edge that samples the final settle tick, power-down wins and `force_zero` stays high.
- R8: Once released, `core_rst`=0, `force_zero`=0, `dout_en`=1 and `clk_en`=1 hold steady for as long as `supply_ok` and `pdn_n` stay high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| supply_ok | input | 1 | Supply-good flag; low resets the sequencer asynchronously |
| pdn_n | input | 1 | Power-down request, active low |
| fs_tick | input | 1 | One-cycle pulse at each sample-period (frame) boundary |
| core_rst | output | 1 | Internal reset for the digital core |
| force_zero | output | 1 | Forces zero data on the serial output |
| dout_en | output | 1 | Serial data output enable |
| clk_en | output | 1 | Digital clock enable |

## Verification
The collision that matters is a power-down request landing on the same edge as the last settle tick, which would otherwise release the mute. The bench watches its own tick count. It drives `pdn_n` low exactly as it schedules that final tick, and expects the mute to hold and the output enable to drop after the edge. A second overlap is a sample tick landing on the edge that releases reset. The bench sweeps the tick period from two to six cycles so that this happens, and checks at every release that exactly SETTLE_SAMPLES ticks were counted and that the release edge carried a tick.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        PH_RESET  = 2'd0,
        PH_SETTLE = 2'd1,
        PH_RUN    = 2'd2,
        PH_PDOWN  = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e phase;
    } seq_state_t;

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] limit,
    output logic          done
);

    logic [CW-1:0] cnt_d, cnt_q;

    // Terminal count is reached on the increment that would make cnt equal limit.
    assign done = inc && (cnt_q == (limit - CW'(1)));

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R2: the count never reaches the limit of the phase it serves
    p_cnt_below_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < limit);

endmodule

// File: rtl/adc_seq_outdec.sv
module adc_seq_outdec
    import adc_seq_pkg::*;
(
    input  phase_e phase,
    output logic   core_rst,
    output logic   force_zero,
    output logic   dout_en,
    output logic   clk_en
);

    always_comb begin
        core_rst   = (phase == PH_RESET) || (phase == PH_PDOWN);
        force_zero = (phase != PH_RUN);
        dout_en    = (phase != PH_PDOWN);
        clk_en     = (phase != PH_PDOWN);
    end

endmodule

// File: rtl/adc_startup_seq.sv
module adc_startup_seq
    import adc_seq_pkg::*;
#(
    parameter int RST_CYCLES     = 1024,
    parameter int SETTLE_SAMPLES = 4480
) (
    input  logic clk,
    input  logic supply_ok,
    input  logic pdn_n,
    input  logic fs_tick,
    output logic core_rst,
    output logic force_zero,
    output logic dout_en,
    output logic clk_en
);

    localparam int MAXL = (RST_CYCLES > SETTLE_SAMPLES) ? RST_CYCLES : SETTLE_SAMPLES;
    localparam int CW   = $clog2(MAXL + 1);
    localparam logic [CW-1:0] RST_L = CW'(RST_CYCLES);
    localparam logic [CW-1:0] SET_L = CW'(SETTLE_SAMPLES);

    seq_state_t    st_d, st_q;
    logic          tmr_inc;
    logic          tmr_clr;
    logic          tmr_done;
    logic [CW-1:0] tmr_limit;

    // Time base per phase: system clock in reset, sample ticks in settle.
    assign tmr_inc   = (st_q.phase == PH_RESET) ||
                       ((st_q.phase == PH_SETTLE) && fs_tick);
    assign tmr_limit = (st_q.phase == PH_SETTLE) ? SET_L : RST_L;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_RESET:  if (tmr_done) st_d.phase = PH_SETTLE;
            PH_SETTLE: if (tmr_done) st_d.phase = PH_RUN;
            PH_RUN:    st_d.phase = PH_RUN;
            PH_PDOWN:  st_d.phase = PH_RESET;
            default:   st_d.phase = PH_RESET;
        endcase
        // Power-down overrides every phase, including a terminal tick.
        if (!pdn_n) begin
            st_d.phase = PH_PDOWN;
        end
        tmr_clr = !pdn_n || (st_d.phase != st_q.phase);
    end

    always_ff @(posedge clk or negedge supply_ok) begin
        if (!supply_ok) begin
            st_q <= '{phase: PH_RESET};
        end else begin
            st_q <= st_d;
        end
    end

    adc_seq_timer #(
        .CW (CW)
    ) u_timer (
        .clk   (clk),
        .rst_n (supply_ok),
        .clr   (tmr_clr),
        .inc   (tmr_inc),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    adc_seq_outdec u_outdec (
        .phase      (st_q.phase),
        .core_rst   (core_rst),
        .force_zero (force_zero),
        .dout_en    (dout_en),
        .clk_en     (clk_en)
    );

    // R5: a sampled power-down request gates clock and output next cycle
    p_pdn_gates_r5: assert property (@(posedge clk) disable iff (!supply_ok)
        !pdn_n |=> (!dout_en && !clk_en && core_rst && force_zero));

    // R4: the mute is lifted only on an edge that sampled a frame tick
    p_release_on_tick_r4: assert property (@(posedge clk) disable iff (!supply_ok)
        $fell(force_zero) |-> $past(fs_tick));

    // R6: leaving power-down always re-enters the reset phase
    p_pdn_exit_resets_r6: assert property (@(posedge clk) disable iff (!supply_ok)
        $rose(dout_en) |-> core_rst);

    // R8: running state is kept while power-down stays inactive
    p_run_holds_r8: assert property (@(posedge clk) disable iff (!supply_ok)
        (!force_zero && pdn_n) |=> (!force_zero && !core_rst));

endmodule

// File: tb/adc_startup_seq_bench.sv
`timescale 1ns/1ps
module adc_startup_seq_bench;

    localparam int RC = 12;
    localparam int SS = 5;

    logic clk = 1'b0;
    logic supply_ok = 1'b0;
    logic pdn_n = 1'b1;
    logic fs_tick = 1'b0;
    logic core_rst, force_zero, dout_en, clk_en;

    int nvec = 0;
    int nfail = 0;
    int tick_per = 4;
    bit pd_on_last = 1'b0;

    always #2 clk = ~clk;

    adc_startup_seq #(
        .RST_CYCLES     (RC),
        .SETTLE_SAMPLES (SS)
    ) u_adc_startup_seq (
        .clk        (clk),
        .supply_ok  (supply_ok),
        .pdn_n      (pdn_n),
        .fs_tick    (fs_tick),
        .core_rst   (core_rst),
        .force_zero (force_zero),
        .dout_en    (dout_en),
        .clk_en     (clk_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Tick generator plus release monitor, both at the falling edge.
    initial begin
        int ph = 0;
        int tcnt = 0;
        bit prev_settle = 1'b0;
        bit prev_fz = 1'b1;
        forever begin
            @(negedge clk);
            if (prev_settle && fs_tick) tcnt++;
            if (core_rst) tcnt = 0;
            if (prev_fz && !force_zero) begin
                chk(tcnt == SS, "R3 ticks counted before release", tcnt, SS);
                chk(fs_tick == 1'b1, "R4 release edge carries a tick", int'(fs_tick), 1);
            end
            prev_settle = !core_rst && force_zero;
            prev_fz = force_zero;
            ph = (ph + 1 >= tick_per) ? 0 : ph + 1;
            fs_tick = (ph == 0);
            if (pd_on_last && fs_tick && prev_settle && tcnt == SS - 1) begin
                pdn_n = 1'b0;
                pd_on_last = 1'b0;
            end
        end
    end

    task automatic count_rst(input int exp, input string tag);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (core_rst && n < 1000);
        chk(n == exp, tag, n, exp);
        chk(force_zero == 1'b1, "R4 mute held at reset release", int'(force_zero), 1);
    endtask

    task automatic power_up();
        @(negedge clk);
        supply_ok = 1'b0;
        #1;
        chk(core_rst && force_zero && dout_en && clk_en, "R1 async reset outputs",
            {core_rst, force_zero, dout_en, clk_en}, 4'b1111);
        repeat (2) @(negedge clk);
        supply_ok = 1'b1;
        count_rst(RC, "R2 reset length after supply");
    endtask

    task automatic wait_run();
        int n = 0;
        while (force_zero && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(!core_rst && !force_zero && dout_en && clk_en, "R8 run outputs",
            {core_rst, force_zero, dout_en, clk_en}, 4'b0011);
        repeat (2 * tick_per) begin
            @(negedge clk);
            chk(!core_rst && !force_zero && dout_en && clk_en, "R8 run outputs stable",
                {core_rst, force_zero, dout_en, clk_en}, 4'b0011);
        end
    endtask

    task automatic pd_cycle(input int hold);
        @(negedge clk);
        pdn_n = 1'b0;
        repeat (hold) begin
            @(negedge clk);
            chk(!dout_en && !clk_en && core_rst && force_zero, "R5 power-down outputs",
                {core_rst, force_zero, dout_en, clk_en}, 4'b1100);
        end
        pdn_n = 1'b1;
        count_rst(RC + 1, "R6 reset length after power-down");
        wait_run();
    endtask

    initial begin
        #1;
        chk(core_rst && force_zero && dout_en && clk_en, "R1 outputs at time zero",
            {core_rst, force_zero, dout_en, clk_en}, 4'b1111);
        @(negedge clk);
        chk(core_rst && force_zero && dout_en && clk_en, "R1 outputs with supply low",
            {core_rst, force_zero, dout_en, clk_en}, 4'b1111);

        // Tick period sweep across the whole start-up sequence.
        for (int p = 2; p <= 6; p++) begin
            tick_per = p;
            power_up();
            wait_run();
        end

        // Power-down from run.
        for (int p = 3; p <= 5; p += 2) begin
            tick_per = p;
            pd_cycle(1 + p);
        end

        // Power-down at every offset of the reset phase.
        tick_per = 3;
        for (int k = 0; k < RC; k++) begin
            @(negedge clk);
            supply_ok = 1'b0;
            @(negedge clk);
            supply_ok = 1'b1;
            repeat (k) @(negedge clk);
            pd_cycle(1);
        end

        // Power-down at every offset of the settle phase.
        tick_per = 4;
        for (int k = 0; k < SS * 4; k++) begin
            power_up();
            repeat (k) @(negedge clk);
            if (force_zero) pd_cycle(2);
            else wait_run();
        end

        // Supply drop in the middle of settling.
        for (int k = 1; k <= 7; k += 3) begin
            tick_per = 3;
            power_up();
            repeat (k) @(negedge clk);
            supply_ok = 1'b0;
            #1;
            chk(core_rst && force_zero && dout_en && clk_en, "R1 supply drop in settle",
                {core_rst, force_zero, dout_en, clk_en}, 4'b1111);
            @(negedge clk);
            supply_ok = 1'b1;
            count_rst(RC, "R2 reset length after supply drop");
            wait_run();
        end

        // Power-down on the final settle tick.
        for (int p = 2; p <= 5; p++) begin
            tick_per = p;
            power_up();
            pd_on_last = 1'b1;
            @(negedge pdn_n);
            @(posedge clk);
            #1;
            chk(force_zero == 1'b1, "R7 mute held on colliding tick", int'(force_zero), 1);
            chk(!dout_en && !clk_en, "R7 power-down wins collision",
                {dout_en, clk_en}, 2'b00);
            @(negedge clk);
            pdn_n = 1'b1;
            count_rst(RC + 1, "R6 restart after collision");
            wait_run();
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule